// File: doc/BRIEF.md
# Delegated Interrupt Priority Selector

This block decides, in a single cycle of logic, whether the hart has to take an interrupt now and, if so, which one. It receives the pending and enable vectors, the delegation mask, the current privilege level and the two global enable bits, one for machine level and one for supervisor level. Each interrupt is gated by the rules of the level it belongs to. An interrupt whose delegation bit is clear obeys the machine rule. An interrupt whose delegation bit is set obeys the supervisor rule. Of the interrupts that remain, the one with the lowest bit index wins.

The result is a take strobe and an XLEN-wide cause word. The top bit of the cause word marks it as an interrupt, and the low bits carry the winning index. The surrounding trap logic uses the strobe and the cause to update its own registers and to redirect fetch; that work sits outside this block. A parameter chooses between a registered output (the default, one clock of latency) and a purely combinational path.

Top module: `irq_delegated_select`

## Requirements
- R1: An interrupt can be chosen only if both its pending bit and its enable bit are set. A pending bit whose enable bit is clear never causes a take.
- R2: An interrupt whose delegation bit is 0 is allowed when the privilege input is below machine (values 0, 1 or 2). It is also allowed when the privilege is machine (3) and the machine global enable is 1. At machine level with the machine global enable at 0, it is blocked.
- R3: An interrupt whose delegation bit is 1 is allowed when the privilege is user (0), or when the privilege is supervisor (1) and the supervisor global enable is 1. It is blocked at every other level, including machine.
- R4: The eligible set is the union of the allowed non-delegated interrupts and the allowed delegated interrupts. Both kinds compete in the same selection.
- R5: When several interrupts are eligible, the one with the lowest bit index is chosen.
- R6: When an interrupt is taken, cause bit XLEN-1 is 1 and bits [IDX_W-1:0] hold the chosen index, with IDX_W = clog2(NUM_IRQ). All other cause bits are 0.
- R7: When no interrupt is eligible, the take output is 0 and the cause output is all zeros.
- R8: With REG_OUT=1, the outputs reflect the inputs sampled at the previous rising clock edge. While the synchronous active-high reset is asserted, both outputs are cleared to 0 at each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_IRQ | Pending interrupt bits |
| enab_i | input | NUM_IRQ | Per-interrupt enable bits |
| deleg_i | input | NUM_IRQ | Delegation mask: 1 means the interrupt is handled at supervisor level |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | An interrupt must be taken |
| cause_o | output | XLEN | Cause word: interrupt flag in the top bit, index in the low bits |

## Verification
The machine-rule gate and the supervisor-rule gate both act in the same cycle, so a delegated interrupt and a non-delegated interrupt can both be eligible at once. Only the lowest-index selection decides which one wins. The bench provokes this by marking a low-index interrupt as delegated and a higher-index one as not delegated, then sweeping the privilege level and the supervisor enable. The winner has to switch from the delegated line to the non-delegated one exactly when the supervisor rule blocks the lower index. Each case is judged by comparing the full cause word against a per-bit reference model in the bench, one clock after the stimulus.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_MACH  = 2'd3
  } priv_lvl_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic [NUM_IRQ-1:0] cand_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               m_gie_i,
  input  logic               s_gie_i,
  output logic [NUM_IRQ-1:0] elig_o
);
  logic mach_ok;
  logic sup_ok;

  // level-wide permission, computed once and then spread over the bits
  always_comb begin
    mach_ok = (priv_i < 2'(PRIV_MACH))  || ((priv_i == 2'(PRIV_MACH))  && m_gie_i);
    sup_ok  = (priv_i < 2'(PRIV_SUPER)) || ((priv_i == 2'(PRIV_SUPER)) && s_gie_i);
  end

  assign elig_o = (cand_i & ~deleg_i & {NUM_IRQ{mach_ok}})
                | (cand_i &  deleg_i & {NUM_IRQ{sup_ok}});
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  localparam int IDX_W = idx_width(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] vec_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_IRQ-1:0] lower_set;
  logic [NUM_IRQ-1:0] first_hot;

  assign lower_set[0] = 1'b0;
  for (genvar i = 1; i < NUM_IRQ; i++) begin : g_chain
    assign lower_set[i] = lower_set[i-1] | vec_i[i-1];
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_hot
    assign first_hot[i] = vec_i[i] & ~lower_set[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (first_hot[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  assign found_o = |vec_i;
endmodule

// File: rtl/irq_cause_fmt.sv
module irq_cause_fmt #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 4
) (
  input  logic             found_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [XLEN-1:0]  cause_o
);
  always_comb begin
    cause_o = '0;
    if (found_i) begin
      cause_o[XLEN-1]    = 1'b1;
      cause_o[IDX_W-1:0] = idx_i;
    end
  end
endmodule

// File: rtl/irq_delegated_select.sv
module irq_delegated_select
  import irq_sel_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_IRQ = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] enab_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               m_gie_i,
  input  logic               s_gie_i,
  output logic               take_o,
  output logic [XLEN-1:0]    cause_o
);
  localparam int IDX_W = idx_width(NUM_IRQ);

  logic [NUM_IRQ-1:0] cand;
  logic [NUM_IRQ-1:0] elig;
  logic               found;
  logic [IDX_W-1:0]   win_idx;
  logic [XLEN-1:0]    cause_d;

  assign cand = pend_i & enab_i;

  irq_level_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .cand_i  (cand),
    .deleg_i (deleg_i),
    .priv_i  (priv_i),
    .m_gie_i (m_gie_i),
    .s_gie_i (s_gie_i),
    .elig_o  (elig)
  );

  irq_lowest_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .vec_i   (elig),
    .found_o (found),
    .idx_o   (win_idx)
  );

  irq_cause_fmt #(.XLEN(XLEN), .IDX_W(IDX_W)) u_fmt (
    .found_i (found),
    .idx_i   (win_idx),
    .cause_o (cause_d)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        take_o  <= 1'b0;
        cause_o <= '0;
      end else begin
        take_o  <= found;
        cause_o <= cause_d;
      end
    end
  end else begin : g_comb
    assign take_o  = found;
    assign cause_o = cause_d;
  end
endmodule

// File: rtl/irq_select_checker.sv
module irq_select_checker
  import irq_sel_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_IRQ = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_IRQ-1:0] pend_i,
  input logic [NUM_IRQ-1:0] enab_i,
  input logic [NUM_IRQ-1:0] deleg_i,
  input logic [1:0]         priv_i,
  input logic               m_gie_i,
  input logic               s_gie_i,
  input logic               take_o,
  input logic [XLEN-1:0]    cause_o
);
  localparam int IDX_W = idx_width(NUM_IRQ);

  logic [NUM_IRQ-1:0] d_pend, d_enab, d_deleg;
  logic [1:0]         d_priv;
  logic               d_mgie, d_sgie;
  logic [IDX_W-1:0]   idx;

  assign idx = cause_o[IDX_W-1:0];

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk) begin
      if (rst) begin
        d_pend <= '0; d_enab <= '0; d_deleg <= '0;
        d_priv <= '0; d_mgie <= 1'b0; d_sgie <= 1'b0;
      end else begin
        d_pend <= pend_i; d_enab <= enab_i; d_deleg <= deleg_i;
        d_priv <= priv_i; d_mgie <= m_gie_i; d_sgie <= s_gie_i;
      end
    end

    p_reset_clear_r8: assert property (@(posedge clk)
      rst |=> (!take_o && cause_o == '0));
  end else begin : g_nodly
    assign d_pend = pend_i;  assign d_enab = enab_i; assign d_deleg = deleg_i;
    assign d_priv = priv_i;  assign d_mgie = m_gie_i; assign d_sgie = s_gie_i;
  end

  p_cand_only_r1: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ((32'(idx) < NUM_IRQ) && d_pend[idx] && d_enab[idx]));

  p_mach_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (d_priv == 2'(PRIV_MACH) && !d_mgie) |-> !take_o);

  p_sup_block_r3: assert property (@(posedge clk) disable iff (rst)
    (d_priv == 2'(PRIV_SUPER) && !d_sgie && take_o) |-> !d_deleg[idx]);

  p_user_any_r4: assert property (@(posedge clk) disable iff (rst)
    (d_priv == 2'(PRIV_USER) && (d_pend & d_enab) != '0) |-> take_o);

  p_cause_flag_r6: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (cause_o[XLEN-1] && cause_o[XLEN-2:IDX_W] == '0));

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> (cause_o == '0));
endmodule

bind irq_delegated_select irq_select_checker #(
  .XLEN(XLEN), .NUM_IRQ(NUM_IRQ), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst(rst), .pend_i(pend_i), .enab_i(enab_i), .deleg_i(deleg_i),
  .priv_i(priv_i), .m_gie_i(m_gie_i), .s_gie_i(s_gie_i),
  .take_o(take_o), .cause_o(cause_o)
);

// File: tb/tb_irq_delegated_select.sv
module tb_irq_delegated_select;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN    = 32;
  localparam int NUM_IRQ = 16;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_IRQ-1:0] pend_i = '0, enab_i = '0, deleg_i = '0;
  logic [1:0]         priv_i = 2'd3;
  logic               m_gie_i = 1'b0, s_gie_i = 1'b0;
  logic               take_o;
  logic [XLEN-1:0]    cause_o;

  irq_delegated_select #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst(rst), .pend_i(pend_i), .enab_i(enab_i), .deleg_i(deleg_i),
    .priv_i(priv_i), .m_gie_i(m_gie_i), .s_gie_i(s_gie_i),
    .take_o(take_o), .cause_o(cause_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic            take;
    logic [XLEN-1:0] cause;
    string           tag;
  } exp_t;

  exp_t q[$];
  int n_checks = 0;
  int n_fails  = 0;

  // reference: walk bits from 0 upward, stop at first allowed one
  function automatic exp_t model(input logic [NUM_IRQ-1:0] p, e, d,
                                 input logic [1:0] pr, input logic mg, sg,
                                 input string tag);
    exp_t r;
    r.take = 1'b0; r.cause = '0; r.tag = tag;
    for (int i = 0; i < NUM_IRQ; i++) begin
      logic ok;
      if (d[i]) ok = (pr == 2'd0) || (pr == 2'd1 && sg);
      else      ok = (pr != 2'd3) || mg;
      if (!r.take && p[i] && e[i] && ok) begin
        r.take  = 1'b1;
        r.cause = (XLEN'(1) << (XLEN-1)) | XLEN'(i);
      end
    end
    return r;
  endfunction

  task automatic apply(input logic [NUM_IRQ-1:0] p, e, d,
                       input logic [1:0] pr, input logic mg, sg,
                       input string tag);
    @(negedge clk);
    pend_i = p; enab_i = e; deleg_i = d; priv_i = pr; m_gie_i = mg; s_gie_i = sg;
    q.push_back(model(p, e, d, pr, mg, sg, tag));
  endtask

  task automatic check_reset(input string tag);
    n_checks++;
    if (take_o !== 1'b0 || cause_o !== '0) begin
      n_fails++;
      $display("FAIL %s: take=%0b cause=%h expected take=0 cause=0", tag, take_o, cause_o);
    end
  endtask

  // monitor: one output per clock, compared just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (take_o !== e.take || cause_o !== e.cause) begin
          n_fails++;
          $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
                   e.tag, take_o, cause_o, e.take, e.cause);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    pend_i = 16'hFFFF; enab_i = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1 check_reset("R8 reset state");
    @(negedge clk);
    rst = 1'b0;

    // R1: enable gating
    apply(16'h0008, 16'h0000, 16'h0000, 2'd3, 1'b1, 1'b0, "R1 pending but disabled");
    apply(16'h0008, 16'h0008, 16'h0000, 2'd3, 1'b1, 1'b0, "R1 pending and enabled");
    apply(16'h00F0, 16'h000F, 16'h0000, 2'd0, 1'b0, 1'b0, "R1 disjoint pend/enab");

    // R2: machine rule for non-delegated
    apply(16'h0020, 16'hFFFF, 16'h0000, 2'd3, 1'b0, 1'b1, "R2 machine gie off");
    apply(16'h0020, 16'hFFFF, 16'h0000, 2'd1, 1'b0, 1'b0, "R2 super below machine");
    apply(16'h0020, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0, "R2 user below machine");
    apply(16'h0020, 16'hFFFF, 16'h0000, 2'd2, 1'b0, 1'b0, "R2 level 2 below machine");

    // R3: supervisor rule for delegated
    apply(16'h0002, 16'hFFFF, 16'h0002, 2'd3, 1'b1, 1'b1, "R3 delegated at machine");
    apply(16'h0002, 16'hFFFF, 16'h0002, 2'd1, 1'b1, 1'b0, "R3 super gie off");
    apply(16'h0002, 16'hFFFF, 16'h0002, 2'd1, 1'b0, 1'b1, "R3 super gie on");
    apply(16'h0002, 16'hFFFF, 16'h0002, 2'd0, 1'b0, 1'b0, "R3 user");
    apply(16'h0002, 16'hFFFF, 16'h0002, 2'd2, 1'b1, 1'b1, "R3 level 2 blocks delegated");

    // R4: both kinds compete
    apply(16'h0022, 16'hFFFF, 16'h0002, 2'd1, 1'b0, 1'b0, "R4 deleg low blocked, nondeleg wins");
    apply(16'h0022, 16'hFFFF, 16'h0002, 2'd1, 1'b0, 1'b1, "R4 deleg low allowed wins");
    apply(16'h0022, 16'hFFFF, 16'h0002, 2'd0, 1'b0, 1'b0, "R4 user both allowed");
    apply(16'h0022, 16'hFFFF, 16'h0020, 2'd3, 1'b1, 1'b1, "R4 machine takes nondeleg low");

    // R5 / R6: lowest index and cause format
    apply(16'hF0F0, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0, "R5 lowest of many");
    apply(16'h8000, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0, "R6 top index");
    apply(16'h0001, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0, "R6 index zero");
    apply(16'hFFFF, 16'hFFFE, 16'h0000, 2'd3, 1'b1, 1'b0, "R5 bit0 disabled");

    // R7: nothing eligible
    apply(16'h0000, 16'hFFFF, 16'h0000, 2'd0, 1'b1, 1'b1, "R7 nothing pending");
    apply(16'hFFFF, 16'hFFFF, 16'hFFFF, 2'd3, 1'b1, 1'b1, "R7 all delegated at machine");

    // mixed vectors, one per clock
    for (int k = 0; k < 300; k++) begin
      apply(NUM_IRQ'($urandom), NUM_IRQ'($urandom), NUM_IRQ'($urandom),
            2'($urandom), 1'($urandom), 1'($urandom), "R5 R8 random stream");
    end

    // R8: reset in mid-run clears outputs
    wait (q.size() == 0);
    @(negedge clk);
    pend_i = 16'h0001; enab_i = 16'h0001; priv_i = 2'd0;
    rst = 1'b1;
    @(posedge clk);
    #1 check_reset("R8 reset mid-run");
    @(negedge clk);
    rst = 1'b0;
    apply(16'h0400, 16'h0400, 16'h0000, 2'd1, 1'b0, 1'b0, "R8 after reset");

    wait (q.size() == 0);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule